// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor fetch 32-bit words from a serial NOR flash as if it were ordinary memory. A read on the word bus becomes one complete single-lane flash read. Chip select goes low and the engine sends the read opcode, then the 24-bit byte address, then a programmable run of dummy clocks. It then clocks in one 32-bit word and hands it back on the bus with a single-cycle acknowledge. A bus write is acknowledged at once and never reaches the flash.

Every phase goes to one shared bit shifter as a payload and a length. The payload is left-aligned, so its most significant bit leaves first, and received bits enter at the bottom. A second requester, a raw serial port driven by registers, can use the same pins to send arbitrary segments. A two-way arbiter decides which side owns the shifter and chip select. The owner keeps the pins for as long as it keeps its request up.

Top module: `spi_flash_reader`

## Requirements
- R1: A bus read sends, MSB first on the single data-out line, the opcode 0x03 (8 bits) and then the byte address formed as {word address, 2'b00} (24 bits).
- R2: After the address the engine sends dummy clocks, as many as `cfg_dummy_i` (0 to 32) held when the read was accepted. A value of 0 leaves the phase out, so one read has exactly 64 + dummy rising SCK edges.
- R3: The data phase samples 32 bits, and the first bit received lands in bit 31 of `bus_rdata_o`. The word therefore holds the flash bytes at the byte address and the three addresses after it, highest byte first.
- R4: SCK idles low and is high for CLK_DIV/2 clock cycles per pulse. MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R5: CSn stays low from before the first command bit until after the last data bit, with one falling edge per read. Between two low periods it stays high for at least CLK_DIV clock cycles.
- R6: `bus_ack_o` is high for exactly one cycle per request, and `bus_rdata_o` is valid in that cycle.
- R7: A bus write is acknowledged in the cycle after it is accepted, and CSn never falls for it.
- R8: A raw segment of length L (1 to 32) sends the low L bits of `raw_data_i`, MSB first. When `raw_done_o` pulses for one cycle, the low L bits of `raw_rdata_o` hold the L received bits, first bit highest.
- R9: The arbiter keeps the grant with its holder until the holder drops its request, and moves it only if the other side is requesting. After reset the bus side holds the grant.
- R10: `raw_ready_o` is high only while the raw port holds the grant, is requesting, has CSn low and has no segment in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request, held until ack |
| bus_we_i | input | 1 | 1 = write (acknowledged only) |
| bus_addr_i | input | ADDR_W | Word address |
| cfg_dummy_i | input | 6 | Dummy clock count, 0..32 |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| bus_rdata_o | output | 32 | Read data |
| raw_req_i | input | 1 | Raw port claims the pins and holds CSn low |
| raw_valid_i | input | 1 | Start a segment while ready |
| raw_data_i | input | 32 | Segment payload, right-aligned |
| raw_len_i | input | 6 | Segment bit count, 1..32 |
| raw_ready_o | output | 1 | Raw port may start a segment |
| raw_done_o | output | 1 | Segment finished |
| raw_rdata_o | output | 32 | Bits received during the segment |
| sck_o | output | 1 | Serial clock |
| csn_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
A flash model in the bench answers reads with a byte pattern computed from the address. Seeded random word addresses and dummy counts show whether address bits and byte order come out right; the directed extremes (address zero, all-ones, no dummy clocks, 32 dummy clocks) expose off-by-one errors in phase lengths and a dummy phase that is not skipped. Raw segments of different lengths, sent back to back under one chip select, test the left alignment of the payload and the packing of received bits. Overlapping requests from both ports, in both orders, show whether the grant really holds until its owner lets go.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;
  localparam logic [7:0] CMD_READ = 8'h03;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CMD,
    SEQ_ADDR,
    SEQ_DUMMY,
    SEQ_DATA,
    SEQ_ACK
  } seq_state_e;
endpackage

// File: rtl/spi_arb2.sv
module spi_arb2 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  output logic       grant_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_o <= 1'b0;
    else if (!req_i[grant_o] && req_i[~grant_o]) grant_o <= ~grant_o;
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int CLK_DIV = 4,
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              miso_i,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(HALF) + 1;

  logic [WORD_W-1:0] sr_q;
  logic [LEN_W-1:0]  cnt_q, shamt;
  logic [DIV_W-1:0]  div_q;
  logic              busy_q, samp_q;

  assign shamt  = LEN_W'(WORD_W) - len_i;
  assign rx_o   = sr_q;
  assign mosi_o = sr_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      samp_q <= 1'b0;
      sck_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        sr_q   <= data_i << shamt;
        cnt_q  <= len_i;
        div_q  <= '0;
        sck_o  <= 1'b0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (div_q == DIV_W'(HALF - 1)) begin
          div_q <= '0;
          sck_o <= ~sck_o;
          if (!sck_o) begin
            samp_q <= miso_i;           // rising edge: sample
          end else begin                // falling edge: advance
            sr_q  <= {sr_q[WORD_W-2:0], samp_q};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == LEN_W'(1)) begin
              busy_q <= 1'b0;
              done_o <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_mmap_seq.sv
module spi_mmap_seq
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LEN_W-1:0]  dummy_i,
  output logic              bus_ack_o,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              req_o,
  input  logic              ready_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_i,
  output logic              start_o,
  output logic [WORD_W-1:0] data_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int BYTE_AW = ADDR_W + 2;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  dummy_q;
  logic              phase;

  assign phase     = (state_q != SEQ_IDLE) && (state_q != SEQ_ACK);
  assign req_o     = phase;
  assign start_o   = phase && ready_i;
  assign bus_ack_o = (state_q == SEQ_ACK);

  always_comb begin
    data_o = '0;
    len_o  = '0;
    case (state_q)
      SEQ_CMD:   begin data_o = WORD_W'(CMD_READ);          len_o = LEN_W'(8);       end
      SEQ_ADDR:  begin data_o = WORD_W'({addr_q, 2'b00});   len_o = LEN_W'(BYTE_AW); end
      SEQ_DUMMY: begin data_o = '0;                         len_o = dummy_q;         end
      SEQ_DATA:  begin data_o = '0;                         len_o = LEN_W'(WORD_W);  end
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      addr_q      <= '0;
      dummy_q     <= '0;
      bus_rdata_o <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (bus_valid_i) begin
          addr_q  <= bus_addr_i;
          dummy_q <= dummy_i;
          state_q <= bus_we_i ? SEQ_ACK : SEQ_CMD;
        end
        SEQ_CMD:   if (done_i) state_q <= SEQ_ADDR;
        SEQ_ADDR:  if (done_i) state_q <= (dummy_q == '0) ? SEQ_DATA : SEQ_DUMMY;
        SEQ_DUMMY: if (done_i) state_q <= SEQ_DATA;
        SEQ_DATA:  if (done_i) begin
          bus_rdata_o <= rx_i;
          state_q     <= SEQ_ACK;
        end
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
  import spi_rd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [5:0]        cfg_dummy_i,
  output logic              bus_ack_o,
  output logic [31:0]       bus_rdata_o,
  input  logic              raw_req_i,
  input  logic              raw_valid_i,
  input  logic [31:0]       raw_data_i,
  input  logic [5:0]        raw_len_i,
  output logic              raw_ready_o,
  output logic              raw_done_o,
  output logic [31:0]       raw_rdata_o,
  output logic              sck_o,
  output logic              csn_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int GAP_W = $clog2(CLK_DIV + 1);

  logic              grant_q;
  logic              mm_req, mm_start, mm_ready;
  logic [WORD_W-1:0] mm_data, seg_data, rx;
  logic [LEN_W-1:0]  mm_len, seg_len;
  logic              seg_start, seg_done, seg_ready, raw_start, cs_want;
  logic              csn_q, pend_q;
  logic [GAP_W-1:0]  gap_q;

  spi_arb2 i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   ({raw_req_i, mm_req}),
    .grant_o (grant_q)
  );

  spi_mmap_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .dummy_i     (cfg_dummy_i),
    .bus_ack_o   (bus_ack_o),
    .bus_rdata_o (bus_rdata_o),
    .req_o       (mm_req),
    .ready_i     (mm_ready),
    .done_i      (seg_done && !grant_q),
    .rx_i        (rx),
    .start_o     (mm_start),
    .data_o      (mm_data),
    .len_o       (mm_len)
  );

  // Shifter is free once CSn is down and the last segment has finished
  assign seg_ready   = !csn_q && !pend_q;
  assign mm_ready    = seg_ready && !grant_q;
  assign raw_ready_o = seg_ready && grant_q && raw_req_i;
  assign raw_start   = raw_valid_i && raw_ready_o;

  assign seg_start = grant_q ? raw_start  : mm_start;
  assign seg_data  = grant_q ? raw_data_i : mm_data;
  assign seg_len   = grant_q ? raw_len_i  : mm_len;
  assign cs_want   = grant_q ? raw_req_i  : mm_req;

  assign raw_done_o  = seg_done && grant_q;
  assign raw_rdata_o = rx;
  assign csn_o       = csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q  <= 1'b1;
      gap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (!cs_want) begin
        csn_q <= 1'b1;
        if (!csn_q) gap_q <= GAP_W'(CLK_DIV);
        else if (gap_q != '0) gap_q <= gap_q - 1'b1;
      end else if (csn_q) begin
        if (gap_q == '0) csn_q <= 1'b0;
        else gap_q <= gap_q - 1'b1;
      end
      if (seg_start) pend_q <= 1'b1;
      else if (seg_done) pend_q <= 1'b0;
    end
  end

  spi_bit_shifter #(.CLK_DIV(CLK_DIV), .WORD_W(WORD_W), .LEN_W(LEN_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (seg_start),
    .data_i  (seg_data),
    .len_i   (seg_len),
    .miso_i  (miso_i),
    .done_o  (seg_done),
    .rx_o    (rx),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o)
  );
endmodule

// File: rtl/spi_flash_reader_chk.sv
module spi_flash_reader_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_o,
  input logic csn_o,
  input logic mosi_o,
  input logic bus_ack_o,
  input logic raw_ready_o,
  input logic raw_done_o,
  input logic grant_i
);
  localparam int HALF = CLK_DIV / 2;

  logic [7:0] hi_cnt, gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= '0;
      gap_cnt <= 8'(CLK_DIV);
    end else begin
      hi_cnt  <= sck_o ? ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1) : '0;
      gap_cnt <= csn_o ? ((gap_cnt == 8'hff) ? gap_cnt : gap_cnt + 1'b1) : '0;
    end
  end

  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);

  p_sck_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_o |-> !sck_o);

  p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> (!sck_o || $stable(mosi_o)));

  p_sck_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> (hi_cnt == 8'(HALF)));

  p_csn_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csn_o) |-> (gap_cnt >= 8'(CLK_DIV)));

  p_raw_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_ready_o |-> (grant_i && !csn_o));

  p_raw_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_done_o |=> !raw_done_o);
endmodule

bind spi_flash_reader spi_flash_reader_chk #(.CLK_DIV(CLK_DIV)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sck_o       (sck_o),
  .csn_o       (csn_o),
  .mosi_o      (mosi_o),
  .bus_ack_o   (bus_ack_o),
  .raw_ready_o (raw_ready_o),
  .raw_done_o  (raw_done_o),
  .grant_i     (grant_q)
);

// File: tb/test_spi_flash_reader.sv
`timescale 1ns/1ps
module test_spi_flash_reader;
  localparam int CLK_DIV = 4;
  localparam int ADDR_W  = 22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [5:0] cfg_dummy = '0;
  logic bus_ack;
  logic [31:0] bus_rdata;
  logic raw_req = 0, raw_valid = 0;
  logic [31:0] raw_data = '0;
  logic [5:0] raw_len = '0;
  logic raw_ready, raw_done;
  logic [31:0] raw_rdata;
  logic sck, csn, mosi, miso = 1'b0;

  always #2 clk = ~clk;

  spi_flash_reader #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) i_spi_flash_reader (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .cfg_dummy_i(cfg_dummy), .bus_ack_o(bus_ack), .bus_rdata_o(bus_rdata),
    .raw_req_i(raw_req), .raw_valid_i(raw_valid), .raw_data_i(raw_data),
    .raw_len_i(raw_len), .raw_ready_o(raw_ready), .raw_done_o(raw_done),
    .raw_rdata_o(raw_rdata),
    .sck_o(sck), .csn_o(csn), .mosi_o(mosi), .miso_i(miso)
  );

  int n_cmp = 0, n_err = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3c;
  endfunction

  function automatic logic [31:0] fword(input logic [23:0] a);
    return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
  endfunction

  // flash model, evaluated away from the active edge
  bit          raw_mode = 0;
  logic [31:0] raw_pat = 32'h9b3e_c571;
  int          cur_dummy = 0;
  int          k = 0;
  logic [127:0] hist = '0;
  logic [23:0] addr_seen = '0;
  logic        sck_prev = 0, in_txn = 0;
  int          csn_falls = 0, sck_bad = 0, gap_bad = 0, hi_run = 0, csn_hi_run = 100;

  function automatic logic next_bit(input int j);
    int d;
    if (raw_mode) return raw_pat[31 - (j % 32)];
    if (j < 32 + cur_dummy) return 1'b0;
    d = j - 32 - cur_dummy;
    return fbyte(addr_seen + 24'(d / 8))[7 - (d % 8)];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (sck) hi_run++;
      else begin
        if (sck_prev && hi_run != CLK_DIV / 2) sck_bad++;
        hi_run = 0;
      end
      if (csn) begin
        in_txn = 0;
        csn_hi_run++;
      end else begin
        if (!in_txn) begin
          in_txn = 1;
          csn_falls++;
          if (csn_hi_run < CLK_DIV) gap_bad++;
          k = 0;
          hist = '0;
          miso = next_bit(0);
        end
        csn_hi_run = 0;
        if (sck && !sck_prev) begin
          hist = {hist[126:0], mosi};
          k++;
          if (k == 32) addr_seen = hist[23:0];
        end
        if (!sck && sck_prev) miso = next_bit(k);
      end
      sck_prev = sck;
    end
  end

  task automatic do_read(input logic [ADDR_W-1:0] wa, input int d, input string tag);
    logic [23:0] ba;
    int f0;
    bit got;
    ba = {wa, 2'b00};
    f0 = csn_falls;
    got = 0;
    @(negedge clk);
    cur_dummy = d;
    cfg_dummy = 6'(d);
    bus_addr = wa;
    bus_we = 0;
    bus_valid = 1;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (bus_ack) got = 1;
    end
    chk({"R6 ack seen ", tag}, 64'(got), 64'd1);
    chk({"R3 read data ", tag}, 64'(bus_rdata), 64'(fword(ba)));
    bus_valid = 0;
    @(negedge clk);
    chk({"R6 ack one cycle ", tag}, 64'(bus_ack), 64'd0);
    chk({"R2 sck edge count ", tag}, 64'(k), 64'(64 + d));
    chk({"R1 opcode ", tag}, 64'((hist >> (k - 8)) & 128'hff), 64'h03);
    chk({"R1 byte address ", tag}, 64'((hist >> (k - 32)) & 128'hff_ffff), 64'(ba));
    chk({"R5 one csn fall ", tag}, 64'(csn_falls - f0), 64'd1);
  endtask

  task automatic raw_seg(input logic [31:0] dat, input int len, input int s);
    logic [63:0] tmp;
    logic [31:0] exp_rx, mask;
    bit got;
    got = 0;
    for (int i = 0; i < 1000 && !got; i++) begin
      @(negedge clk);
      if (raw_ready) got = 1;
    end
    chk("R10 raw ready", 64'(got), 64'd1);
    raw_data = dat;
    raw_len = 6'(len);
    raw_valid = 1;
    @(negedge clk);
    raw_valid = 0;
    got = 0;
    for (int i = 0; i < 1000 && !got; i++) begin
      if (raw_done) got = 1;
      else @(negedge clk);
    end
    chk("R8 raw done", 64'(got), 64'd1);
    mask = (len == 32) ? 32'hffff_ffff : ((32'd1 << len) - 32'd1);
    tmp = {raw_pat, 32'd0} << s;
    exp_rx = tmp[63:32] >> (32 - len);
    chk("R8 raw rx bits", 64'(raw_rdata & mask), 64'(exp_rx));
    chk("R8 raw tx bits", 64'(hist[31:0] & mask), 64'(dat & mask));
    @(negedge clk);
    chk("R8 raw done one cycle", 64'(raw_done), 64'd0);
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    int f0, ackc, rdy;
    bit got;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R5 reset csn high", 64'(csn), 64'd1);
    chk("R4 reset sck low", 64'(sck), 64'd0);
    chk("R6 reset ack low", 64'(bus_ack), 64'd0);
    chk("R10 reset raw ready low", 64'(raw_ready), 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R9 bus side owns after reset (no raw ready)", 64'(raw_ready), 64'd0);

    // directed corners
    do_read('0, 0, "addr0 d0");
    do_read('1, 32, "addrmax d32");
    do_read(22'h15_5aa3, 8, "d8");
    do_read(22'h2a_0f0f, 1, "d1");

    // write: ack only
    f0 = csn_falls;
    @(negedge clk);
    bus_we = 1; bus_valid = 1; bus_addr = 22'h12345;
    @(negedge clk);
    chk("R7 write ack next cycle", 64'(bus_ack), 64'd1);
    bus_valid = 0; bus_we = 0;
    repeat (20) @(negedge clk);
    chk("R7 write no csn", 64'(csn_falls - f0), 64'd0);

    // random reads
    for (int n = 0; n < 30; n++)
      do_read(ADDR_W'($urandom), int'($urandom_range(32, 0)), "random");

    // raw segments under one chip select
    raw_mode = 1;
    raw_req = 1;
    raw_seg(32'h0000_00a5, 8, 0);
    raw_seg(32'hdead_c3e1, 16, 8);
    raw_seg(32'h0000_0001, 1, 24);
    raw_seg(32'h1234_5678, 7, 25);
    // bus read arrives while raw holds the grant
    @(negedge clk);
    cur_dummy = 4; cfg_dummy = 6'd4; bus_addr = 22'h0a_bcde; bus_valid = 1;
    ackc = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bus_ack) ackc++;
    end
    chk("R9 bus waits while raw holds grant", 64'(ackc), 64'd0);
    raw_seg(32'hffff_0000, 32, 0);
    chk("R5 csn stays low for raw holder", 64'(csn), 64'd0);
    raw_mode = 0;
    raw_req = 0;
    got = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (bus_ack) got = 1;
    end
    chk("R9 bus served after raw release", 64'(got), 64'd1);
    chk("R9 data after handover", 64'(bus_rdata), 64'(fword({22'h0a_bcde, 2'b00})));
    bus_valid = 0;
    repeat (2) @(negedge clk);

    // raw requests during a bus read
    cur_dummy = 2; cfg_dummy = 6'd2; bus_addr = 22'h3f_0001; bus_valid = 1;
    repeat (10) @(negedge clk);
    raw_req = 1;
    rdy = 0; got = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (raw_ready) rdy++;
      if (bus_ack) got = 1;
    end
    chk("R10 no raw ready during bus read", 64'(rdy), 64'd0);
    chk("R3 data with raw waiting", 64'(bus_rdata), 64'(fword({22'h3f_0001, 2'b00})));
    bus_valid = 0;
    got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (raw_ready) got = 1;
    end
    chk("R9 raw granted after bus drops", 64'(got), 64'd1);
    raw_req = 0;
    repeat (20) @(negedge clk);

    chk("R4 sck high width", 64'(sck_bad), 64'd0);
    chk("R5 csn high gap", 64'(gap_bad), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule